// File: doc/BRIEF.md
# Video Gain, Offset and Clip Stage

This block scales and shifts 10-bit component video samples one at a time and then forces the result into a legal code range. Every sample arrives with a component tag and a valid strobe. The tag picks one of three independent gain/offset pairs, one each for luma, blue-difference and red-difference. Luma is scaled about code zero. Chroma is scaled about the mid code 512, so a gain change alters saturation without moving the neutral point. The offset is then added in quarter-code steps. The sum is rounded to a whole code and clipped.

The legalizer enable selects the clip window. When it is on, luma and chroma each get their own broadcast-legal range. When it is off, a single wider range still keeps the codes reserved for timing words out of the picture. The pipeline has a fixed depth of three registers. The tag and strobe travel alongside the data, so a downstream stage sees each corrected sample together with its own tag.

Top module: `gol_legalizer`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: A sample captured at rising edge k leaves with `out_valid` high and its own tag on `out_comp` after edge k+2, which is the third edge counting the capturing one. `out_valid` is low in every cycle that has no such sample.
- R3: For luma, `out_data` is the clipped, rounded value of X·G/8192 + O/4. G is the 15-bit unsigned gain, where 8192 is unity and 32767 is about 4x. O is the 13-bit two's-complement luma offset in quarter codes, range −4095..4095.
- R4: For chroma, `out_data` is the clipped, rounded value of (X−512)·G/8192 + 512 + O/4. O is a 12-bit two's-complement offset in quarter codes, range −2047..2047.
- R5: Tag 0 selects luma, tag 1 blue chroma and tag 2 red chroma. Tag 3 is processed as luma and is passed through unchanged on `out_comp`. Each tag uses only its own gain and offset inputs.
- R6: A result exactly halfway between two codes rounds toward the higher code, for both positive and negative intermediate values.
- R7: With `legal_en` = 1, luma is clipped to 64..940 and chroma to 64..960.
- R8: With `legal_en` = 0, every component is clipped to 4..1019.
- R9: Gains, offsets and `legal_en` are taken in the same cycle as the sample. A change in a later cycle does not affect a sample already accepted.
- R10: With gain 0, luma gives the clipped round(O/4) and chroma gives the clipped 512 + round(O/4), whatever the input code.
- R11: In a cycle where `out_valid` is low, `out_data` keeps the last valid result (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_comp | input | 2 | Component tag (0 Y, 1 Cb, 2 Cr, 3 as Y) |
| in_data | input | 10 | Input sample code |
| legal_en | input | 1 | 1 selects the narrow legal windows |
| gain_y | input | 15 | Luma gain, 8192 = unity |
| gain_cb | input | 15 | Blue chroma gain |
| gain_cr | input | 15 | Red chroma gain |
| ofs_y | input | 13 | Luma offset, signed quarter codes |
| ofs_cb | input | 12 | Blue chroma offset, signed quarter codes |
| ofs_cr | input | 12 | Red chroma offset, signed quarter codes |
| out_valid | output | 1 | Result strobe |
| out_comp | output | 2 | Tag of the result |
| out_data | output | 10 | Corrected, clipped code |

## Verification
The properties assume that `in_valid`, `in_comp` and `legal_en` have settled values from the first edge after reset release. They compare outputs only against inputs captured since that edge, so no value driven during reset is ever consulted. The window properties need no assumption about gain or offset. Still, the stimulus keeps every offset inside its stated quarter-code range and every gain within 0..32767. Full code sweeps on each tag cover identity, doubling, halving (which produces exact ties), zero gain and maximum gain. A final stretch changes the whole configuration, the tag and the strobe on every cycle.

// File: rtl/gol_pkg.sv
package gol_pkg;

    typedef enum logic [1:0] {
        COMP_Y  = 2'd0,
        COMP_CB = 2'd1,
        COMP_CR = 2'd2,
        COMP_XY = 2'd3
    } comp_e;

    localparam int NUM_COMP = 3;

endpackage

// File: rtl/gol_scale_stage.sv
module gol_scale_stage
    import gol_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int GAIN_W = 15,
    parameter int OFS_W  = 13,
    parameter int NCOMP  = NUM_COMP,
    parameter int PROD_W = DATA_W + GAIN_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               in_comp,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     legal_en,
    input  logic [NCOMP*GAIN_W-1:0]  gain_bus,
    input  logic [NCOMP*OFS_W-1:0]   ofs_bus,
    output logic                     s1_valid,
    output logic [1:0]               s1_comp,
    output logic                     s1_chroma,
    output logic                     s1_legal,
    output logic signed [PROD_W-1:0] s1_prod,
    output logic signed [OFS_W-1:0]  s1_ofs
);

    localparam int CEN_W = DATA_W + 1;
    localparam logic signed [CEN_W-1:0] MID_CODE = CEN_W'(1) << (DATA_W - 1);

    logic [GAIN_W-1:0] gain_arr [NCOMP];
    logic [OFS_W-1:0]  ofs_arr  [NCOMP];

    generate
        for (genvar gi = 0; gi < NCOMP; gi++) begin : g_unpack
            assign gain_arr[gi] = gain_bus[gi*GAIN_W +: GAIN_W];
            assign ofs_arr[gi]  = ofs_bus[gi*OFS_W +: OFS_W];
        end
    endgenerate

    logic [1:0]               sel_idx;
    logic                     sel_chroma;
    logic signed [CEN_W-1:0]  centered;
    logic signed [GAIN_W:0]   gain_s;
    logic signed [PROD_W-1:0] prod_c;

    always_comb begin
        // tag 3 falls back to the luma settings
        sel_idx    = (in_comp == COMP_XY) ? 2'(COMP_Y) : in_comp;
        sel_chroma = (sel_idx != 2'(COMP_Y));
        if (sel_chroma) begin
            centered = $signed({1'b0, in_data}) - MID_CODE;
        end else begin
            centered = $signed({1'b0, in_data});
        end
        gain_s = $signed({1'b0, gain_arr[sel_idx]});
        prod_c = PROD_W'(centered) * PROD_W'(gain_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_comp   <= '0;
            s1_chroma <= 1'b0;
            s1_legal  <= 1'b0;
            s1_prod   <= '0;
            s1_ofs    <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_comp   <= in_comp;
            s1_chroma <= sel_chroma;
            s1_legal  <= legal_en;
            s1_prod   <= prod_c;
            s1_ofs    <= $signed(ofs_arr[sel_idx]);
        end
    end

endmodule

// File: rtl/gol_round_stage.sv
module gol_round_stage #(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 13,
    parameter int OFS_W  = 13,
    parameter int PROD_W = 27,
    parameter int RES_W  = PROD_W + 2 - FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic [1:0]               s1_comp,
    input  logic                     s1_chroma,
    input  logic                     s1_legal,
    input  logic signed [PROD_W-1:0] s1_prod,
    input  logic signed [OFS_W-1:0]  s1_ofs,
    output logic                     s2_valid,
    output logic [1:0]               s2_comp,
    output logic                     s2_chroma,
    output logic                     s2_legal,
    output logic signed [RES_W-1:0]  s2_res
);

    localparam int SUM_W = PROD_W + 2;
    // chroma pivot moved back to the mid code, in fixed-point units
    localparam logic signed [SUM_W-1:0] CHROMA_BIAS = SUM_W'(1) << (DATA_W - 1 + FRAC_W);
    localparam logic signed [SUM_W-1:0] HALF_LSB    = SUM_W'(1) << (FRAC_W - 1);

    logic signed [SUM_W-1:0] prod_ext;
    logic signed [SUM_W-1:0] ofs_ext;
    logic signed [SUM_W-1:0] bias;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] shifted;

    always_comb begin
        prod_ext = SUM_W'(s1_prod);
        // quarter-code offset scaled to the fraction width
        ofs_ext  = SUM_W'(s1_ofs) <<< (FRAC_W - 2);
        bias     = s1_chroma ? CHROMA_BIAS : '0;
        sum      = prod_ext + ofs_ext + bias + HALF_LSB;
        shifted  = sum >>> FRAC_W;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_comp   <= '0;
            s2_chroma <= 1'b0;
            s2_legal  <= 1'b0;
            s2_res    <= '0;
        end else begin
            s2_valid  <= s1_valid;
            s2_comp   <= s1_comp;
            s2_chroma <= s1_chroma;
            s2_legal  <= s1_legal;
            s2_res    <= shifted[RES_W-1:0];
        end
    end

endmodule

// File: rtl/gol_clip_stage.sv
module gol_clip_stage #(
    parameter int DATA_W     = 10,
    parameter int RES_W      = 16,
    parameter int Y_LEGAL_LO = 64,
    parameter int Y_LEGAL_HI = 940,
    parameter int C_LEGAL_LO = 64,
    parameter int C_LEGAL_HI = 960,
    parameter int WIDE_LO    = 4,
    parameter int WIDE_HI    = 1019
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s2_valid,
    input  logic [1:0]              s2_comp,
    input  logic                    s2_chroma,
    input  logic                    s2_legal,
    input  logic signed [RES_W-1:0] s2_res,
    output logic                    out_valid,
    output logic [1:0]              out_comp,
    output logic [DATA_W-1:0]       out_data
);

    localparam logic signed [RES_W-1:0] YLO = RES_W'(Y_LEGAL_LO);
    localparam logic signed [RES_W-1:0] YHI = RES_W'(Y_LEGAL_HI);
    localparam logic signed [RES_W-1:0] CLO = RES_W'(C_LEGAL_LO);
    localparam logic signed [RES_W-1:0] CHI = RES_W'(C_LEGAL_HI);
    localparam logic signed [RES_W-1:0] WLO = RES_W'(WIDE_LO);
    localparam logic signed [RES_W-1:0] WHI = RES_W'(WIDE_HI);

    logic signed [RES_W-1:0] lo_lim;
    logic signed [RES_W-1:0] hi_lim;
    logic signed [RES_W-1:0] clipped;

    always_comb begin
        unique case ({s2_legal, s2_chroma})
            2'b10:   begin lo_lim = YLO; hi_lim = YHI; end
            2'b11:   begin lo_lim = CLO; hi_lim = CHI; end
            default: begin lo_lim = WLO; hi_lim = WHI; end
        endcase
        if (s2_res < lo_lim) begin
            clipped = lo_lim;
        end else if (s2_res > hi_lim) begin
            clipped = hi_lim;
        end else begin
            clipped = s2_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_comp  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_comp <= s2_comp;
                out_data <= clipped[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gol_legalizer.sv
module gol_legalizer
    import gol_pkg::*;
#(
    parameter int DATA_W     = 10,
    parameter int GAIN_W     = 15,
    parameter int FRAC_W     = 13,
    parameter int LOFS_W     = 13,
    parameter int COFS_W     = 12,
    parameter int Y_LEGAL_LO = 64,
    parameter int Y_LEGAL_HI = 940,
    parameter int C_LEGAL_LO = 64,
    parameter int C_LEGAL_HI = 960,
    parameter int WIDE_LO    = 4,
    parameter int WIDE_HI    = 1019
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_comp,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               legal_en,
    input  logic [GAIN_W-1:0]  gain_y,
    input  logic [GAIN_W-1:0]  gain_cb,
    input  logic [GAIN_W-1:0]  gain_cr,
    input  logic [LOFS_W-1:0]  ofs_y,
    input  logic [COFS_W-1:0]  ofs_cb,
    input  logic [COFS_W-1:0]  ofs_cr,
    output logic               out_valid,
    output logic [1:0]         out_comp,
    output logic [DATA_W-1:0]  out_data
);

    localparam int OFS_W  = (LOFS_W > COFS_W) ? LOFS_W : COFS_W;
    localparam int PROD_W = DATA_W + GAIN_W + 2;
    localparam int RES_W  = PROD_W + 2 - FRAC_W;

    logic [NUM_COMP*GAIN_W-1:0] gain_bus;
    logic [NUM_COMP*OFS_W-1:0]  ofs_bus;

    assign gain_bus = {gain_cr, gain_cb, gain_y};
    assign ofs_bus  = {{{(OFS_W-COFS_W){ofs_cr[COFS_W-1]}}, ofs_cr},
                       {{(OFS_W-COFS_W){ofs_cb[COFS_W-1]}}, ofs_cb},
                       {{(OFS_W-LOFS_W){ofs_y[LOFS_W-1]}}, ofs_y}};

    logic                     s1_valid;
    logic [1:0]               s1_comp;
    logic                     s1_chroma;
    logic                     s1_legal;
    logic signed [PROD_W-1:0] s1_prod;
    logic signed [OFS_W-1:0]  s1_ofs;

    logic                     s2_valid;
    logic [1:0]               s2_comp;
    logic                     s2_chroma;
    logic                     s2_legal;
    logic signed [RES_W-1:0]  s2_res;

    gol_scale_stage #(
        .DATA_W (DATA_W),
        .GAIN_W (GAIN_W),
        .OFS_W  (OFS_W),
        .NCOMP  (NUM_COMP),
        .PROD_W (PROD_W)
    ) scale_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_comp   (in_comp),
        .in_data   (in_data),
        .legal_en  (legal_en),
        .gain_bus  (gain_bus),
        .ofs_bus   (ofs_bus),
        .s1_valid  (s1_valid),
        .s1_comp   (s1_comp),
        .s1_chroma (s1_chroma),
        .s1_legal  (s1_legal),
        .s1_prod   (s1_prod),
        .s1_ofs    (s1_ofs)
    );

    gol_round_stage #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .OFS_W  (OFS_W),
        .PROD_W (PROD_W),
        .RES_W  (RES_W)
    ) round_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_comp   (s1_comp),
        .s1_chroma (s1_chroma),
        .s1_legal  (s1_legal),
        .s1_prod   (s1_prod),
        .s1_ofs    (s1_ofs),
        .s2_valid  (s2_valid),
        .s2_comp   (s2_comp),
        .s2_chroma (s2_chroma),
        .s2_legal  (s2_legal),
        .s2_res    (s2_res)
    );

    gol_clip_stage #(
        .DATA_W     (DATA_W),
        .RES_W      (RES_W),
        .Y_LEGAL_LO (Y_LEGAL_LO),
        .Y_LEGAL_HI (Y_LEGAL_HI),
        .C_LEGAL_LO (C_LEGAL_LO),
        .C_LEGAL_HI (C_LEGAL_HI),
        .WIDE_LO    (WIDE_LO),
        .WIDE_HI    (WIDE_HI)
    ) clip_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s2_valid  (s2_valid),
        .s2_comp   (s2_comp),
        .s2_chroma (s2_chroma),
        .s2_legal  (s2_legal),
        .s2_res    (s2_res),
        .out_valid (out_valid),
        .out_comp  (out_comp),
        .out_data  (out_data)
    );

endmodule

// File: rtl/gol_legalizer_chk.sv
module gol_legalizer_chk #(
    parameter int DATA_W     = 10,
    parameter int Y_LEGAL_LO = 64,
    parameter int Y_LEGAL_HI = 940,
    parameter int C_LEGAL_LO = 64,
    parameter int C_LEGAL_HI = 960,
    parameter int WIDE_LO    = 4,
    parameter int WIDE_HI    = 1019
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_comp,
    input logic              legal_en,
    input logic              out_valid,
    input logic [1:0]        out_comp,
    input logic [DATA_W-1:0] out_data
);

    // edges seen since reset release, saturating at the pipeline depth
    logic [1:0] warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (!out_valid && out_data == '0)
                else $error("outputs not idle during reset");
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_comp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid) |-> (out_comp == $past(in_comp, 3)));

    assert_luma_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $past(legal_en, 3) && (out_comp == 2'd0 || out_comp == 2'd3))
        |-> (out_data >= DATA_W'(Y_LEGAL_LO) && out_data <= DATA_W'(Y_LEGAL_HI)));

    assert_chroma_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && out_valid && $past(legal_en, 3) && (out_comp == 2'd1 || out_comp == 2'd2))
        |-> (out_data >= DATA_W'(C_LEGAL_LO) && out_data <= DATA_W'(C_LEGAL_HI)));

    assert_outer_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data >= DATA_W'(WIDE_LO) && out_data <= DATA_W'(WIDE_HI)));

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !out_valid) |-> $stable(out_data));

endmodule

bind gol_legalizer gol_legalizer_chk #(
    .DATA_W     (DATA_W),
    .Y_LEGAL_LO (Y_LEGAL_LO),
    .Y_LEGAL_HI (Y_LEGAL_HI),
    .C_LEGAL_LO (C_LEGAL_LO),
    .C_LEGAL_HI (C_LEGAL_HI),
    .WIDE_LO    (WIDE_LO),
    .WIDE_HI    (WIDE_HI)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_comp   (in_comp),
    .legal_en  (legal_en),
    .out_valid (out_valid),
    .out_comp  (out_comp),
    .out_data  (out_data)
);

// File: tb/gol_legalizer_tb.sv
`timescale 1ns/1ps
module gol_legalizer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_comp = '0;
    logic [9:0]  in_data = '0;
    logic        legal_en = 1'b0;
    logic [14:0] gain_y = '0, gain_cb = '0, gain_cr = '0;
    logic [12:0] ofs_y = '0;
    logic [11:0] ofs_cb = '0, ofs_cr = '0;
    logic        out_valid;
    logic [1:0]  out_comp;
    logic [9:0]  out_data;

    always #2.5 clk = ~clk;

    gol_legalizer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_comp(in_comp),
        .in_data(in_data), .legal_en(legal_en),
        .gain_y(gain_y), .gain_cb(gain_cb), .gain_cr(gain_cr),
        .ofs_y(ofs_y), .ofs_cb(ofs_cb), .ofs_cr(ofs_cr),
        .out_valid(out_valid), .out_comp(out_comp), .out_data(out_data)
    );

    int total = 0;
    int fails = 0;
    int cfg_gain [3];
    int cfg_ofs  [3];
    bit cfg_legal;

    // bench-side model of the three register delay
    bit         pv [3];
    logic [1:0] pc [3];
    int         pd [3];
    string      pt [3];
    int         last_data = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    function automatic longint floordiv(input longint n, input longint d);
        longint q;
        q = n / d;
        if ((n % d != 0) && (n < 0)) q = q - 1;
        return q;
    endfunction

    task automatic model(input logic [1:0] c, input int x, output int val, output string tag);
        int     idx;
        bit     chroma;
        longint base, num, r, lo, hi, rem;
        idx    = (c == 2'd3) ? 0 : int'(c);
        chroma = (idx != 0);
        base   = chroma ? 512 : 0;
        num    = (longint'(x) - base) * longint'(cfg_gain[idx])
                 + longint'(cfg_ofs[idx]) * 2048 + base * 8192;
        r      = floordiv(num + 4096, 8192);
        rem    = ((num % 8192) + 8192) % 8192;
        if (cfg_legal) begin
            lo = 64;
            hi = chroma ? 960 : 940;
        end else begin
            lo = 4;
            hi = 1019;
        end
        if (cfg_gain[idx] == 0)      tag = "R10";
        else if (rem == 4096)        tag = "R6";
        else if (chroma)             tag = "R4";
        else                         tag = "R3";
        if (r < lo) begin
            r = lo; tag = cfg_legal ? "R7" : "R8";
        end else if (r > hi) begin
            r = hi; tag = cfg_legal ? "R7" : "R8";
        end
        val = int'(r);
    endtask

    task automatic apply_cfg();
        gain_y   = 15'(cfg_gain[0]);
        gain_cb  = 15'(cfg_gain[1]);
        gain_cr  = 15'(cfg_gain[2]);
        ofs_y    = 13'(cfg_ofs[0]);
        ofs_cb   = 12'(cfg_ofs[1]);
        ofs_cr   = 12'(cfg_ofs[2]);
        legal_en = cfg_legal;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(input bit v, input logic [1:0] c, input int x);
        int    ev;
        string et;
        in_valid = v;
        in_comp  = c;
        in_data  = 10'(x);
        apply_cfg();
        model(c, x, ev, et);
        @(posedge clk);
        pv[2] = pv[1]; pc[2] = pc[1]; pd[2] = pd[1]; pt[2] = pt[1];
        pv[1] = pv[0]; pc[1] = pc[0]; pd[1] = pd[0]; pt[1] = pt[0];
        pv[0] = v;     pc[0] = c;     pd[0] = ev;    pt[0] = et;
        @(negedge clk);
        chk(out_valid == pv[2], "R2", int'(out_valid), int'(pv[2]));
        if (pv[2]) begin
            chk(out_comp == pc[2], "R2/R5", int'(out_comp), int'(pc[2]));
            chk(int'(out_data) == pd[2], pt[2], int'(out_data), pd[2]);
            last_data = pd[2];
        end else begin
            chk(int'(out_data) == last_data, "R11", int'(out_data), last_data);
        end
    endtask

    task automatic set_cfg(input int gy, input int gb, input int gr,
                           input int oy, input int ob, input int orr, input bit lg);
        cfg_gain[0] = gy; cfg_gain[1] = gb; cfg_gain[2] = gr;
        cfg_ofs[0]  = oy; cfg_ofs[1]  = ob; cfg_ofs[2]  = orr;
        cfg_legal   = lg;
    endtask

    task automatic sweep(input int bubble_every);
        for (int c = 0; c < 3; c++) begin
            for (int x = 0; x < 1024; x++) begin
                if (bubble_every > 0 && (x % bubble_every) == 0) drive(1'b0, 2'(c), x);
                drive(1'b1, 2'(c), x);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            pv[i] = 1'b0; pc[i] = '0; pd[i] = 0; pt[i] = "R2";
        end
        set_cfg(8192, 8192, 8192, 0, 0, 0, 1'b0);
        apply_cfg();
        // R1: idle outputs during reset
        repeat (4) begin
            @(negedge clk);
            chk(!out_valid && out_data == '0, "R1", int'(out_data), 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) drive(1'b0, 2'd0, 0);

        // identity, wide window (R3, R4, R8)
        set_cfg(8192, 8192, 8192, 0, 0, 0, 1'b0);
        sweep(0);
        // identity, legal windows (R7)
        set_cfg(8192, 8192, 8192, 0, 0, 0, 1'b1);
        sweep(7);
        // independent per-component settings (R5)
        set_cfg(16384, 12000, 4000, -400, 300, -2047, 1'b1);
        sweep(0);
        // zero gain (R10)
        set_cfg(0, 0, 0, 1234, -901, 2047, 1'b0);
        sweep(0);
        // maximum gain and offsets (R3, R4, R8)
        set_cfg(32767, 32767, 32767, 4095, 2047, -2047, 1'b0);
        sweep(5);
        // half gain with half-code offsets: exact ties (R6)
        set_cfg(4096, 4096, 4096, 2, -2, 2, 1'b0);
        sweep(0);
        set_cfg(4096, 4096, 4096, -2, 2, -4095 + 4093, 1'b0);
        sweep(0);
        // configuration changing on every sample (R9), tag 3 (R5), bubbles (R11)
        for (int n = 0; n < 6000; n++) begin
            set_cfg(int'($urandom_range(0, 32767)), int'($urandom_range(0, 32767)),
                    int'($urandom_range(0, 32767)),
                    int'($urandom_range(0, 8190)) - 4095,
                    int'($urandom_range(0, 4094)) - 2047,
                    int'($urandom_range(0, 4094)) - 2047,
                    1'($urandom_range(0, 1)));
            drive(($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
                  int'($urandom_range(0, 1023)));
        end
        for (int i = 0; i < 4; i++) drive(1'b0, 2'd0, 0);
        finish_run();
    end

endmodule